// File: doc/BRIEF.md
# Logic Analyzer Command Decoder

This block sits behind a UART receiver and turns the incoming byte stream into the control state of a sampling logic analyzer. Every command starts with an opcode byte. When the opcode's top bit is clear, the command is that single byte. When the top bit is set, exactly four data bytes follow it. The four data bytes are packed least-significant byte first into one 32-bit word.

Long commands load a register file. The register file holds the sample-clock divider, the read and delay counts, the flag word, and the mask, value and configuration words of each trigger stage. Short commands raise one-cycle strobes toward the rest of the analyzer: reset, arm (run) and metadata request. The identify command makes the block send a fixed four-byte signature through a valid/ready transmit interface.

A host that has lost track of framing can send the reset opcode five times in a row. That always brings the decoder back to an idle frame boundary.

Top module: `la_cmd_decoder`

## Requirements
- R1: An opcode byte with bit 7 clear is a complete command. An opcode byte with bit 7 set is followed by exactly four data bytes, and none of those data bytes is decoded as a command, whatever its value.
- R2: Opcode 0x00 raises `reset_pulse_o` for exactly one cycle. The pulse is high in the cycle that follows the clock edge that accepted the byte.
- R3: Opcode 0x01 raises `arm_pulse_o` for one cycle. Opcode 0x04 raises `meta_pulse_o` for one cycle. Both use the same timing as R2.
- R4: Opcode 0x02 makes the block transmit 0x31, 0x53, 0x4C, 0x4F in that order. Each byte is held stable on `tx_data_o` with `tx_valid_o` high until a cycle in which `tx_ready_i` is high.
- R5: An identify opcode that arrives while a reply is still being transmitted is ignored. No extra bytes are sent.
- R6: Opcode 0x80 loads the divider. Data byte 1 becomes bits 7:0, byte 2 becomes bits 15:8 and byte 3 becomes bits 23:16. Byte 4 lies above the default 24-bit divider and is dropped.
- R7: Opcode 0x81 loads the read count from data bytes 1 (low) and 2 (high), and the delay count from data bytes 3 (low) and 4 (high).
- R8: Opcode 0x82 loads the flag word: data byte 1 is bits 7:0 and byte 2 is bits 15:8. Bytes 3 and 4 are dropped. `group_en_o[g]` is the inverse of flag bit 2+g, for g = 0..3.
- R9: For trigger stage k, opcode 0xC0+4k loads the mask word, 0xC1+4k the value word and 0xC2+4k the configuration word. All three are packed as in R6, and stage k occupies bits 32k+31:32k of each flat output. `start_stage_o[k]` equals bit 3 of stage k's configuration word.
- R10: Five consecutive 0x00 bytes leave the decoder at a frame boundary, from any position inside a frame, so that the next byte is decoded as an opcode.
- R11: An unknown opcode (for example 0x03, 0x83, 0xC3) consumes one or five bytes according to its bit 7. It changes no register and raises no strobe.
- R12: After reset all registers read zero, no strobe is high and `tx_valid_o` is low.
- R13: A register changes only on a completed long command that carries its own opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_data_i | input | 8 | Received byte |
| rx_valid_i | input | 1 | Received byte is valid this cycle |
| tx_ready_i | input | 1 | Transmitter accepts `tx_data_o` this cycle |
| tx_data_o | output | 8 | Identify reply byte |
| tx_valid_o | output | 1 | Reply byte is valid |
| reset_pulse_o | output | 1 | One-cycle reset strobe |
| arm_pulse_o | output | 1 | One-cycle arm strobe |
| ident_pulse_o | output | 1 | One-cycle identify strobe |
| meta_pulse_o | output | 1 | One-cycle metadata request strobe |
| divider_o | output | DIV_W | Sample clock divider N (rate = base / (N+1)) |
| read_cnt_o | output | CNT_W | Read count minus one, in units of four samples |
| delay_cnt_o | output | CNT_W | Delay count minus one, in units of four samples |
| flags_o | output | FLAG_W | Flag word |
| group_en_o | output | 4 | Channel group enables, derived from flag bits 5:2 |
| trig_mask_o | output | 32*NUM_STAGES | Trigger mask words, stage k at bits 32k+31:32k |
| trig_value_o | output | 32*NUM_STAGES | Trigger value words |
| trig_cfg_o | output | 32*NUM_STAGES | Trigger configuration words |
| start_stage_o | output | NUM_STAGES | Per stage: the stage starts the capture |

## Verification
The bench builds the decoder with its defaults: four trigger stages, a 24-bit divider, 16-bit counts and a 16-bit flag word. With four stages, the whole 0xC0 to 0xCF opcode range is live. With a 24-bit divider, the dropped fourth divider byte is observable. With 16-bit counts, both halves of the size word appear unmodified at the ports. The reset-sequence recovery is driven from every position inside a frame, zero to four data bytes deep. The identify reply is run under transmit backpressure.

// File: rtl/la_cmd_pkg.sv
package la_cmd_pkg;
  localparam int unsigned LONG_BYTES = 4;
  localparam int unsigned WORD_W     = 8 * LONG_BYTES;
  localparam int unsigned NUM_GROUPS = 4;
  localparam int unsigned GROUP_LSB  = 2;
  localparam int unsigned START_BIT  = 3;

  localparam logic [7:0] OP_RESET = 8'h00;
  localparam logic [7:0] OP_RUN   = 8'h01;
  localparam logic [7:0] OP_IDENT = 8'h02;
  localparam logic [7:0] OP_META  = 8'h04;
  localparam logic [7:0] OP_DIV   = 8'h80;
  localparam logic [7:0] OP_SIZE  = 8'h81;
  localparam logic [7:0] OP_FLAGS = 8'h82;
  localparam logic [7:0] OP_TRIG  = 8'hC0;

  // reply bytes, index 0 sent first
  localparam int unsigned   ID_LEN   = 4;
  localparam logic [31:0]   ID_REPLY = {8'h4F, 8'h4C, 8'h53, 8'h31};

  typedef struct packed {
    logic              long_cmd;
    logic [7:0]        op;
    logic [WORD_W-1:0] word;
  } cmd_t;
endpackage

// File: rtl/la_cmd_framer.sv
module la_cmd_framer
  import la_cmd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] rx_data_i,
  input  logic       rx_valid_i,
  output cmd_t       cmd_o,
  output logic       cmd_valid_o,
  output logic       in_frame_o
);
  localparam int unsigned LEFT_W = $clog2(LONG_BYTES + 1);

  logic [LEFT_W-1:0] left_q;
  logic [7:0]        op_q;
  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] word_next;

  // little-endian assembly: first data byte ends at bits 7:0
  assign word_next  = {rx_data_i, word_q[WORD_W-1:8]};
  assign in_frame_o = (left_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q      <= '0;
      op_q        <= '0;
      word_q      <= '0;
      cmd_valid_o <= 1'b0;
      cmd_o       <= '0;
    end else begin
      cmd_valid_o <= 1'b0;
      if (rx_valid_i) begin
        if (left_q == '0) begin
          op_q <= rx_data_i;
          if (rx_data_i[7]) begin
            left_q <= LEFT_W'(LONG_BYTES);
            word_q <= '0;
          end else begin
            cmd_valid_o    <= 1'b1;
            cmd_o.long_cmd <= 1'b0;
            cmd_o.op       <= rx_data_i;
            cmd_o.word     <= '0;
          end
        end else begin
          word_q <= word_next;
          left_q <= left_q - 1'b1;
          if (left_q == LEFT_W'(1)) begin
            cmd_valid_o    <= 1'b1;
            cmd_o.long_cmd <= 1'b1;
            cmd_o.op       <= op_q;
            cmd_o.word     <= word_next;
          end
        end
      end
    end
  end
endmodule

// File: rtl/la_cmd_regs.sv
module la_cmd_regs
  import la_cmd_pkg::*;
#(
  parameter int unsigned NUM_STAGES = 4,
  parameter int unsigned DIV_W      = 24,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned FLAG_W     = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  cmd_t                         cmd_i,
  input  logic                         cmd_valid_i,
  output logic [DIV_W-1:0]             divider_o,
  output logic [CNT_W-1:0]             read_cnt_o,
  output logic [CNT_W-1:0]             delay_cnt_o,
  output logic [FLAG_W-1:0]            flags_o,
  output logic [NUM_STAGES*WORD_W-1:0] trig_mask_o,
  output logic [NUM_STAGES*WORD_W-1:0] trig_value_o,
  output logic [NUM_STAGES*WORD_W-1:0] trig_cfg_o,
  output logic [NUM_STAGES-1:0]        start_stage_o
);
  localparam int unsigned HALF_W = WORD_W / 2;

  logic long_hit;
  logic unused_word;

  assign long_hit    = cmd_valid_i && cmd_i.long_cmd;
  assign unused_word = ^cmd_i.word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      divider_o   <= '0;
      read_cnt_o  <= '0;
      delay_cnt_o <= '0;
      flags_o     <= '0;
    end else if (long_hit) begin
      case (cmd_i.op)
        OP_DIV:   divider_o <= cmd_i.word[DIV_W-1:0];
        OP_SIZE: begin
          read_cnt_o  <= cmd_i.word[CNT_W-1:0];
          delay_cnt_o <= cmd_i.word[HALF_W +: CNT_W];
        end
        OP_FLAGS: flags_o <= cmd_i.word[FLAG_W-1:0];
        default: ;
      endcase
    end
  end

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    localparam logic [7:0] OP_M = OP_TRIG | 8'(4 * s);
    logic [WORD_W-1:0] mask_q, value_q, cfg_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mask_q  <= '0;
        value_q <= '0;
        cfg_q   <= '0;
      end else if (long_hit) begin
        if (cmd_i.op == OP_M)           mask_q  <= cmd_i.word;
        if (cmd_i.op == (OP_M | 8'h01)) value_q <= cmd_i.word;
        if (cmd_i.op == (OP_M | 8'h02)) cfg_q   <= cmd_i.word;
      end
    end

    assign trig_mask_o[s*WORD_W +: WORD_W]  = mask_q;
    assign trig_value_o[s*WORD_W +: WORD_W] = value_q;
    assign trig_cfg_o[s*WORD_W +: WORD_W]   = cfg_q;
    assign start_stage_o[s]                 = cfg_q[START_BIT];
  end
endmodule

// File: rtl/la_cmd_idtx.sv
module la_cmd_idtx
  import la_cmd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       tx_ready_i,
  output logic [7:0] tx_data_o,
  output logic       tx_valid_o
);
  localparam int unsigned IDX_W = $clog2(ID_LEN);

  logic [IDX_W-1:0] idx_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      busy_q <= 1'b0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
      end
    end else if (tx_ready_i) begin
      if (idx_q == IDX_W'(ID_LEN - 1)) busy_q <= 1'b0;
      else                              idx_q  <= idx_q + 1'b1;
    end
  end

  assign tx_valid_o = busy_q;
  assign tx_data_o  = ID_REPLY[{idx_q, 3'b000} +: 8];
endmodule

// File: rtl/la_cmd_decoder.sv
module la_cmd_decoder
  import la_cmd_pkg::*;
#(
  parameter int unsigned NUM_STAGES = 4,
  parameter int unsigned DIV_W      = 24,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned FLAG_W     = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [7:0]                   rx_data_i,
  input  logic                         rx_valid_i,
  input  logic                         tx_ready_i,
  output logic [7:0]                   tx_data_o,
  output logic                         tx_valid_o,
  output logic                         reset_pulse_o,
  output logic                         arm_pulse_o,
  output logic                         ident_pulse_o,
  output logic                         meta_pulse_o,
  output logic [DIV_W-1:0]             divider_o,
  output logic [CNT_W-1:0]             read_cnt_o,
  output logic [CNT_W-1:0]             delay_cnt_o,
  output logic [FLAG_W-1:0]            flags_o,
  output logic [NUM_GROUPS-1:0]        group_en_o,
  output logic [NUM_STAGES*WORD_W-1:0] trig_mask_o,
  output logic [NUM_STAGES*WORD_W-1:0] trig_value_o,
  output logic [NUM_STAGES*WORD_W-1:0] trig_cfg_o,
  output logic [NUM_STAGES-1:0]        start_stage_o
);
  cmd_t cmd;
  logic cmd_valid;
  logic in_frame;
  logic short_hit;

  la_cmd_framer u_framer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rx_data_i   (rx_data_i),
    .rx_valid_i  (rx_valid_i),
    .cmd_o       (cmd),
    .cmd_valid_o (cmd_valid),
    .in_frame_o  (in_frame)
  );

  assign short_hit     = cmd_valid && !cmd.long_cmd;
  assign reset_pulse_o = short_hit && (cmd.op == OP_RESET);
  assign arm_pulse_o   = short_hit && (cmd.op == OP_RUN);
  assign ident_pulse_o = short_hit && (cmd.op == OP_IDENT);
  assign meta_pulse_o  = short_hit && (cmd.op == OP_META);

  la_cmd_regs #(
    .NUM_STAGES (NUM_STAGES),
    .DIV_W      (DIV_W),
    .CNT_W      (CNT_W),
    .FLAG_W     (FLAG_W)
  ) u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cmd_i         (cmd),
    .cmd_valid_i   (cmd_valid),
    .divider_o     (divider_o),
    .read_cnt_o    (read_cnt_o),
    .delay_cnt_o   (delay_cnt_o),
    .flags_o       (flags_o),
    .trig_mask_o   (trig_mask_o),
    .trig_value_o  (trig_value_o),
    .trig_cfg_o    (trig_cfg_o),
    .start_stage_o (start_stage_o)
  );

  // flag bit = 1 disables the group
  assign group_en_o = ~flags_o[GROUP_LSB +: NUM_GROUPS];

  la_cmd_idtx u_idtx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (ident_pulse_o),
    .tx_ready_i (tx_ready_i),
    .tx_data_o  (tx_data_o),
    .tx_valid_o (tx_valid_o)
  );
endmodule

// File: rtl/la_cmd_decoder_chk.sv
module la_cmd_decoder_chk #(
  parameter int unsigned DIV_W  = 24,
  parameter int unsigned FLAG_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reset_pulse_o,
  input logic              arm_pulse_o,
  input logic              ident_pulse_o,
  input logic              meta_pulse_o,
  input logic              tx_valid_o,
  input logic              tx_ready_i,
  input logic [7:0]        tx_data_o,
  input logic [DIV_W-1:0]  divider_o,
  input logic [FLAG_W-1:0] flags_o,
  input logic              cmd_valid,
  input logic              in_frame
);
  logic any_pulse;
  assign any_pulse = reset_pulse_o | arm_pulse_o | ident_pulse_o | meta_pulse_o;

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({reset_pulse_o, arm_pulse_o, ident_pulse_o, meta_pulse_o})); // R1

  AST_NO_STROBE_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_pulse |-> !in_frame); // R1

  AST_TX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o))); // R4

  AST_TX_FIRST_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_valid_o) |-> (tx_data_o == 8'h31)); // R4

  AST_DIV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid |=> $stable(divider_o)); // R13

  AST_FLAGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid |=> $stable(flags_o)); // R13
endmodule

bind la_cmd_decoder la_cmd_decoder_chk #(.DIV_W(DIV_W), .FLAG_W(FLAG_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .reset_pulse_o (reset_pulse_o),
  .arm_pulse_o   (arm_pulse_o),
  .ident_pulse_o (ident_pulse_o),
  .meta_pulse_o  (meta_pulse_o),
  .tx_valid_o    (tx_valid_o),
  .tx_ready_i    (tx_ready_i),
  .tx_data_o     (tx_data_o),
  .divider_o     (divider_o),
  .flags_o       (flags_o),
  .cmd_valid     (cmd_valid),
  .in_frame      (in_frame)
);

// File: tb/la_cmd_decoder_bench.sv
module la_cmd_decoder_bench;
  localparam int unsigned NS = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [7:0]    rx_data_i = '0;
  logic          rx_valid_i = 1'b0;
  logic          tx_ready_i = 1'b1;
  logic [7:0]    tx_data_o;
  logic          tx_valid_o;
  logic          reset_pulse_o, arm_pulse_o, ident_pulse_o, meta_pulse_o;
  logic [23:0]   divider_o;
  logic [15:0]   read_cnt_o, delay_cnt_o, flags_o;
  logic [3:0]    group_en_o;
  logic [NS*32-1:0] trig_mask_o, trig_value_o, trig_cfg_o;
  logic [NS-1:0] start_stage_o;

  always #10 clk_i = ~clk_i;

  la_cmd_decoder u_la_cmd_decoder (.*);

  int checks = 0;
  int failures = 0;
  int n_reset = 0, n_arm = 0, n_ident = 0, n_meta = 0, n_tx = 0;
  logic [7:0] exp_q[$];

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: strobe counts and reply scoreboard
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (reset_pulse_o) n_reset++;
      if (arm_pulse_o)   n_arm++;
      if (ident_pulse_o) n_ident++;
      if (meta_pulse_o)  n_meta++;
      if (tx_valid_o && tx_ready_i) begin
        n_tx++;
        if (exp_q.size() == 0) chk("R5 unexpected tx byte", {120'h0, tx_data_o}, 128'hFFF);
        else chk("R4 tx byte", {120'h0, tx_data_o}, {120'h0, exp_q.pop_front()});
      end
    end
  end

  task automatic send(input logic [7:0] b);
    @(negedge clk_i);
    rx_data_i  = b;
    rx_valid_i = 1'b1;
    @(negedge clk_i);
    rx_valid_i = 1'b0;
  endtask

  task automatic send_long(input logic [7:0] op, input logic [31:0] w);
    send(op);
    for (int i = 0; i < 4; i++) send(w[8*i +: 8]);
  endtask

  task automatic expect_id();
    exp_q.push_back(8'h31); exp_q.push_back(8'h53);
    exp_q.push_back(8'h4C); exp_q.push_back(8'h4F);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk_i);
  endtask

  task automatic run_tests();
    int a0, r0, m0, i0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R12 reset state
    chk("R12 divider", divider_o, 0);
    chk("R12 flags", flags_o, 0);
    chk("R12 trig", {trig_mask_o[31:0], trig_value_o[31:0], trig_cfg_o[31:0]}, 0);
    chk("R12 strobes", {reset_pulse_o, arm_pulse_o, ident_pulse_o, meta_pulse_o, tx_valid_o}, 0);

    // R2 / R3 strobe timing and counts
    @(negedge clk_i); rx_data_i = 8'h01; rx_valid_i = 1'b1;
    @(negedge clk_i); rx_valid_i = 1'b0;
    chk("R3 arm pulse in next cycle", arm_pulse_o, 1);
    @(negedge clk_i);
    chk("R3 arm pulse one cycle", arm_pulse_o, 0);
    send(8'h00); send(8'h04); settle();
    chk("R2 reset count", n_reset, 1);
    chk("R3 meta count", n_meta, 1);

    // R1 / R6 divider with data bytes that look like opcodes
    a0 = n_arm; r0 = n_reset; i0 = n_ident;
    send_long(8'h80, 32'h04000201); settle();
    chk("R6 divider", divider_o, 24'h000201);
    chk("R1 no strobes inside frame", {n_arm - a0, n_reset - r0, n_ident - i0}, 0);

    // R7 capture size
    send_long(8'h81, 32'h56781234); settle();
    chk("R7 read count", read_cnt_o, 16'h1234);
    chk("R7 delay count", delay_cnt_o, 16'h5678);

    // R8 flags
    send_long(8'h82, 32'hFFFF013C); settle();
    chk("R8 flags", flags_o, 16'h013C);
    chk("R8 groups all off", group_en_o, 4'b0000);
    send_long(8'h82, 32'h00000014); settle();
    chk("R8 groups mixed", group_en_o, 4'b1010);

    // R9 trigger stages
    send_long(8'hC8, 32'hDEADBEEF);
    send_long(8'hC9, 32'h12345678);
    send_long(8'hCA, 32'h00000008);
    send_long(8'hC0, 32'hA5A5A5A5); settle();
    chk("R9 stage2 mask", trig_mask_o[95:64], 32'hDEADBEEF);
    chk("R9 stage2 value", trig_value_o[95:64], 32'h12345678);
    chk("R9 stage2 cfg", trig_cfg_o[95:64], 32'h8);
    chk("R9 stage0 mask", trig_mask_o[31:0], 32'hA5A5A5A5);
    chk("R9 start stage", start_stage_o, 4'b0100);
    send_long(8'hCE, 32'h00000008); settle();
    chk("R9 stage3 start", start_stage_o, 4'b1100);

    // R11 unknown opcodes
    a0 = n_arm; r0 = n_reset; m0 = n_meta; i0 = n_ident;
    send(8'h03);
    send_long(8'h83, 32'h01020004);
    send_long(8'hC3, 32'hFFFFFFFF);
    send(8'h01); settle();
    chk("R11 only final arm", {n_arm - a0, n_reset - r0, n_meta - m0, n_ident - i0}, {32'd1, 96'd0});
    chk("R11 R13 regs kept", {divider_o, read_cnt_o, flags_o, trig_mask_o[127:96]},
        {24'h000201, 16'h1234, 16'h0014, 32'h0});

    // R10 resync from every frame depth
    for (int p = 0; p <= 4; p++) begin
      a0 = n_arm; r0 = n_reset;
      send(8'hFF);
      for (int k = 0; k < p; k++) send(8'hAA);
      for (int k = 0; k < 5; k++) send(8'h00);
      send(8'h01); settle();
      chk($sformatf("R10 depth %0d arm", p), n_arm - a0, 1);
      chk($sformatf("R10 depth %0d resets", p), n_reset - r0, p + 1);
    end

    // R4 identify with backpressure
    tx_ready_i = 1'b0;
    expect_id();
    send(8'h02); settle();
    chk("R4 hold first byte", {tx_valid_o, tx_data_o}, {1'b1, 8'h31});
    // R5 second identify while busy
    send(8'h02); settle();
    chk("R5 ident strobe seen", n_ident, 2);
    tx_ready_i = 1'b1;
    repeat (12) @(negedge clk_i);
    chk("R5 reply length", n_tx, 4);
    chk("R4 scoreboard drained", exp_q.size(), 0);
    chk("R4 tx idle", tx_valid_o, 0);

    // R4 reply after idle, full rate
    expect_id();
    send(8'h02);
    repeat (10) @(negedge clk_i);
    chk("R4 second reply", n_tx, 8);
  endtask

  initial begin
    bit wd = 1'b0;
    fork
      run_tests();
      begin repeat (50000) @(posedge clk_i); wd = 1'b1; end
    join_any
    disable fork;
    if (wd) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule